// File: doc/BRIEF.md
# Time-Slotted Shared Bus Arbiter

This block shares one byte-wide external bus among three devices: a static RAM, a configuration EEPROM and the parallel control port of a line transceiver. Bus time is cut into a fixed, repeating schedule. There are eight slots of four clock cycles each, and the schedule is clocked from the 20.48 MHz line clock. Even slots belong to the host. Odd slots belong to an internal buffer manager. Ownership never depends on who is asking, so the worst-case latency for either side is fixed.

The buffer manager keeps six FIFO queues in the RAM. Each queue has a 1 KB region, so 6 KB of the 8 KB part is used and the top 2 KB stays free. Queues 0–2 are receive queues for channels 0–2: a channel pushes data into one and the host pops it. Queues 3–5 are transmit queues for channels 0–2: the host pushes data into one and the channel pops it. The host reaches the queues, their status and the three devices through a single request/done handshake. Within each slot the block produces the chip-select, output-enable and write-enable waveforms.

Top module: `tdm_bus_arbiter`

## Requirements
- R1: After reset the schedule repeats every 8 slots of 4 cycles. Even slots serve the host and odd slots serve channels. `host_done` pulses only in cycle 3 of an even slot, and channel done strobes pulse only in cycle 3 of an odd slot. An even slot with no host request stays idle even while channels are waiting.
- R2: In a slot with a bus access, the selected chip select is low in cycles 0–2. `oe_n` (read) or `we_n` (write) is low in cycles 1–2, and the two are never low together. All strobes are high in cycle 3. Read data sampled at the end of cycle 2 appears on the read-data output during cycle 3, together with the done strobe.
- R3: `host_dev` picks the target. 0 is the RAM with the full 13-bit address. 1 is the EEPROM, with `host_addr[10:0]` placed on the bus. 2 is the control port, with `host_addr[3:0]` placed on the bus. At most one chip select is low at any time.
- R4: Entry p of queue q sits at RAM address q*1024 + p.
- R5: `host_dev`=3 with `host_addr[3]`=0 is the queue port, and `host_addr[2:0]` selects the queue. A host write to queue 3–5 pushes `host_wdata`. A host read from queue 0–2 pops one byte.
- R6: While `ch_wr_req[c]` is high, channel c pushes `ch_wdata[8c+7:8c]` into queue c, and each push pulses `ch_wr_done[c]`. While `ch_rd_req[c]` is high, channel c pops queue c+3, and each pop pulses `ch_rd_done[c]` with the byte on `ch_rdata`.
- R7: Odd slots rotate round-robin over queues 0–5, starting after the queue served last (queue 5 after reset). The rotation skips any queue that is not eligible. A receive queue is eligible when its request is high and it is not full. A transmit queue is eligible when its request is high and it is not empty.
- R8: Pointers are 10 bits wide and wrap. A queue becomes full after 1024 pushes with no pop. A push to a full queue or a pop from an empty queue makes no bus cycle and leaves the queue unchanged. A host access of that kind still gets `host_done` with data 0x00, while a channel request of that kind waits.
- R9: `host_dev`=3 with `host_addr[3]`=1 reads the status of queue `host_addr[2:0]` as {6'b0, full, empty} and makes no bus cycle.
- R10: A queue-port access to queue 6 or 7, a host write to a receive queue and a host read from a transmit queue make no bus cycle. Each returns `host_done` with data 0x00.
- R11: During reset and until the first access, every strobe is high and every done output is low. All queues come out of reset empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access request, held until `host_done` |
| host_we | input | 1 | 1 = write, 0 = read |
| host_dev | input | 2 | Target: 0 RAM, 1 EEPROM, 2 control port, 3 queue port |
| host_addr | input | 13 | Host address / queue select |
| host_wdata | input | 8 | Host write data |
| host_done | output | 1 | One-cycle completion of a host access |
| host_rdata | output | 8 | Host read data, valid with `host_done` |
| ch_wr_req | input | 3 | Per-channel push request into receive queue |
| ch_wdata | input | 24 | Per-channel push data, 8 bits per channel |
| ch_wr_done | output | 3 | Per-channel push completion |
| ch_rd_req | input | 3 | Per-channel pop request from transmit queue |
| ch_rd_done | output | 3 | Per-channel pop completion |
| ch_rdata | output | 8 | Popped byte, valid with `ch_rd_done` |
| bus_addr | output | 13 | Shared bus address |
| bus_wdata | output | 8 | Shared bus write data |
| bus_rdata | input | 8 | Shared bus read data |
| sram_cs_n | output | 1 | RAM chip select |
| eep_cs_n | output | 1 | EEPROM chip select |
| ctl_cs_n | output | 1 | Control-port chip select |
| oe_n | output | 1 | Output enable |
| we_n | output | 1 | Write enable |

## Verification
A slot or phase counter that drifts shows up within one slot: done strobes move away from cycle 3, or a strobe appears in a slot owned by the other side. A damaged pointer or flag becomes visible one access later. The next queue transfer lands on the wrong RAM address, or the status byte and the skip behaviour disagree with the push/pop history. A wrong round-robin state shows up as a different order of channel done strobes when several queues are eligible at once.

// File: rtl/tdm_bus_pkg.sv
package tdm_bus_pkg;

  typedef enum logic [1:0] {
    DEV_NONE = 2'd0,
    DEV_SRAM = 2'd1,
    DEV_EEP  = 2'd2,
    DEV_CTL  = 2'd3
  } bus_dev_e;

  typedef enum logic [1:0] {
    QOP_NONE = 2'd0,
    QOP_PUSH = 2'd1,
    QOP_POP  = 2'd2
  } q_op_e;

endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
  parameter int NUM_SLOTS = 8,
  parameter int SW        = 3
) (
  input  logic       clk,
  input  logic       rst_ni,
  output logic [1:0] phase,
  output logic       host_slot
);

  logic [1:0]    phase_d;
  logic [SW-1:0] slot_q, slot_d;

  always_comb begin
    phase_d = phase + 2'd1;
    slot_d  = slot_q;
    if (phase == 2'd3) begin
      slot_d = (slot_q == SW'(NUM_SLOTS - 1)) ? '0 : slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase  <= 2'd0;
      slot_q <= '0;
    end else begin
      phase  <= phase_d;
      slot_q <= slot_d;
    end
  end

  assign host_slot = ~slot_q[0];

  // R1: four cycles per slot, slot index only moves at the slot boundary
  p_phase_wrap_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase == 2'd3) |=> (phase == 2'd0));
  p_slot_steady_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase != 2'd3) |=> $stable(slot_q));
  p_owner_flip_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase == 2'd3) |=> (host_slot != $past(host_slot)));

endmodule

// File: rtl/tdm_queue_ptrs.sv
module tdm_queue_ptrs #(
  parameter int NQ = 6,
  parameter int PW = 10,
  parameter int IW = 3
) (
  input  logic                   clk,
  input  logic                   rst_ni,
  input  logic                   op_en,
  input  logic                   op_push,
  input  logic [IW-1:0]          op_q,
  output logic [NQ-1:0][PW-1:0]  rptr,
  output logic [NQ-1:0][PW-1:0]  wptr,
  output logic [NQ-1:0]          full,
  output logic [NQ-1:0]          empty
);

  for (genvar gi = 0; gi < NQ; gi++) begin : g_q
    logic [PW-1:0] r_q, r_d, w_q, w_d;
    logic          f_q, f_d, e_q, e_d;
    logic          hit;

    assign hit = op_en && (op_q == IW'(gi));

    always_comb begin
      r_d = r_q;
      w_d = w_q;
      f_d = f_q;
      e_d = e_q;
      if (hit && op_push) begin
        w_d = w_q + 1'b1;
        f_d = (w_d == r_q);
        e_d = 1'b0;
      end else if (hit) begin
        r_d = r_q + 1'b1;
        e_d = (r_d == w_q);
        f_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        r_q <= '0;
        w_q <= '0;
        f_q <= 1'b0;
        e_q <= 1'b1;
      end else if (hit) begin
        r_q <= r_d;
        w_q <= w_d;
        f_q <= f_d;
        e_q <= e_d;
      end
    end

    assign rptr[gi]  = r_q;
    assign wptr[gi]  = w_q;
    assign full[gi]  = f_q;
    assign empty[gi] = e_q;

    // R8: flags exclusive, no push into full, no pop from empty
    p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_ni)
      !(f_q && e_q));
    p_no_push_full_r8: assert property (@(posedge clk) disable iff (!rst_ni)
      (hit && op_push) |-> !f_q);
    p_no_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_ni)
      (hit && !op_push) |-> !e_q);
  end

endmodule

// File: rtl/tdm_rr_pick.sv
module tdm_rr_pick #(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic [N-1:0]  elig,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] pick
);

  always_comb begin
    found = 1'b0;
    pick  = last;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(last) + k) % N;
      if (!found && elig[idx]) begin
        found = 1'b1;
        pick  = IW'(idx);
      end
    end
  end

endmodule

// File: rtl/tdm_bus_arbiter.sv
module tdm_bus_arbiter
  import tdm_bus_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int NCH       = 3,
  parameter int PTR_W     = 10,
  parameter int DW        = 8,
  parameter int EEP_AW    = 11,
  parameter int CTL_AW    = 4,
  localparam int NQ       = 2 * NCH,
  localparam int QID_W    = $clog2(NQ),
  localparam int ADDR_W   = QID_W + PTR_W,
  localparam int SW       = $clog2(NUM_SLOTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_req,
  input  logic                host_we,
  input  logic [1:0]          host_dev,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic [DW-1:0]       host_wdata,
  output logic                host_done,
  output logic [DW-1:0]       host_rdata,
  input  logic [NCH-1:0]      ch_wr_req,
  input  logic [NCH*DW-1:0]   ch_wdata,
  output logic [NCH-1:0]      ch_wr_done,
  input  logic [NCH-1:0]      ch_rd_req,
  output logic [NCH-1:0]      ch_rd_done,
  output logic [DW-1:0]       ch_rdata,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DW-1:0]       bus_wdata,
  input  logic [DW-1:0]       bus_rdata,
  output logic                sram_cs_n,
  output logic                eep_cs_n,
  output logic                ctl_cs_n,
  output logic                oe_n,
  output logic                we_n
);

  typedef struct packed {
    logic              valid;
    logic              from_host;
    bus_dev_e          dev;
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [DW-1:0]     wdata;
    q_op_e             qop;
    logic [QID_W-1:0]  q;
    logic              stat;
  } access_t;

  // reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_ni <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_ni <= rst_s1;
    end
  end

  logic [1:0] phase;
  logic       host_slot;

  tdm_slot_timer #(.NUM_SLOTS(NUM_SLOTS), .SW(SW)) i_timer (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .phase    (phase),
    .host_slot(host_slot)
  );

  logic                    slot_end, latch, next_host;
  access_t                 act, nx;
  logic [NQ-1:0][PTR_W-1:0] q_rptr, q_wptr;
  logic [NQ-1:0]           q_full, q_empty;
  logic [NQ-1:0]           elig;
  logic                    found;
  logic [QID_W-1:0]        pick, rr_last, hq;
  logic                    op_en;

  assign slot_end  = (phase == 2'd3);
  assign latch     = (phase == 2'd2);
  assign next_host = ~host_slot;

  tdm_queue_ptrs #(.NQ(NQ), .PW(PTR_W), .IW(QID_W)) i_qptr (
    .clk    (clk),
    .rst_ni (rst_ni),
    .op_en  (op_en),
    .op_push(act.qop == QOP_PUSH),
    .op_q   (act.q),
    .rptr   (q_rptr),
    .wptr   (q_wptr),
    .full   (q_full),
    .empty  (q_empty)
  );

  assign elig = {ch_rd_req & ~q_empty[NQ-1:NCH], ch_wr_req & ~q_full[NCH-1:0]};

  tdm_rr_pick #(.N(NQ), .IW(QID_W)) i_rr (
    .elig (elig),
    .last (rr_last),
    .found(found),
    .pick (pick)
  );

  // next-slot access descriptor
  assign hq = host_addr[QID_W-1:0];

  always_comb begin
    nx = '0;
    if (next_host) begin
      if (host_req) begin
        nx.valid     = 1'b1;
        nx.from_host = 1'b1;
        nx.we        = host_we;
        nx.wdata     = host_wdata;
        unique case (host_dev)
          2'd0: begin
            nx.dev  = DEV_SRAM;
            nx.addr = host_addr;
          end
          2'd1: begin
            nx.dev  = DEV_EEP;
            nx.addr = {{(ADDR_W-EEP_AW){1'b0}}, host_addr[EEP_AW-1:0]};
          end
          2'd2: begin
            nx.dev  = DEV_CTL;
            nx.addr = {{(ADDR_W-CTL_AW){1'b0}}, host_addr[CTL_AW-1:0]};
          end
          default: begin
            nx.q = hq;
            if (host_addr[QID_W]) begin
              nx.stat = 1'b1;
            end else if (int'(hq) < NCH) begin
              if (!host_we && !q_empty[hq]) begin
                nx.dev  = DEV_SRAM;
                nx.qop  = QOP_POP;
                nx.addr = {hq, q_rptr[hq]};
              end
            end else if (int'(hq) < NQ) begin
              if (host_we && !q_full[hq]) begin
                nx.dev  = DEV_SRAM;
                nx.qop  = QOP_PUSH;
                nx.addr = {hq, q_wptr[hq]};
              end
            end
          end
        endcase
      end
    end else if (found) begin
      nx.valid = 1'b1;
      nx.dev   = DEV_SRAM;
      nx.q     = pick;
      if (int'(pick) < NCH) begin
        nx.we    = 1'b1;
        nx.qop   = QOP_PUSH;
        nx.wdata = ch_wdata[int'(pick)*DW +: DW];
        nx.addr  = {pick, q_wptr[pick]};
      end else begin
        nx.qop  = QOP_POP;
        nx.addr = {pick, q_rptr[pick]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      act     <= '0;
      rr_last <= QID_W'(NQ - 1);
    end else if (slot_end) begin
      act <= nx;
      if (!next_host && found) rr_last <= pick;
    end
  end

  // completion path
  logic [DW-1:0] rd_val, rdata_q;
  logic          hdone_q;
  logic [NQ-1:0] bdone_q;

  assign op_en = latch && act.valid && (act.qop != QOP_NONE);

  always_comb begin
    rd_val = '0;
    if (act.stat) begin
      if (int'(act.q) < NQ) rd_val = {{(DW-2){1'b0}}, q_full[act.q], q_empty[act.q]};
    end else if (act.dev != DEV_NONE && !act.we) begin
      rd_val = bus_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      hdone_q <= 1'b0;
      bdone_q <= '0;
    end else begin
      hdone_q <= latch && act.valid && act.from_host;
      bdone_q <= (latch && act.valid && !act.from_host) ? (NQ'(1) << act.q) : '0;
      if (latch && act.valid) rdata_q <= rd_val;
    end
  end

  assign host_done  = hdone_q;
  assign host_rdata = rdata_q;
  assign ch_rdata   = rdata_q;
  assign ch_wr_done = bdone_q[NCH-1:0];
  assign ch_rd_done = bdone_q[NQ-1:NCH];

  // strobe waveforms
  logic bus_act, cs_win, str_win;
  assign bus_act   = act.valid && (act.dev != DEV_NONE);
  assign cs_win    = bus_act && (phase != 2'd3);
  assign str_win   = bus_act && (phase == 2'd1 || phase == 2'd2);
  assign sram_cs_n = !(cs_win && act.dev == DEV_SRAM);
  assign eep_cs_n  = !(cs_win && act.dev == DEV_EEP);
  assign ctl_cs_n  = !(cs_win && act.dev == DEV_CTL);
  assign oe_n      = !(str_win && !act.we);
  assign we_n      = !(str_win && act.we);
  assign bus_addr  = act.addr;
  assign bus_wdata = act.wdata;

  // R3: one device selected at a time
  p_one_cs_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({~sram_cs_n, ~eep_cs_n, ~ctl_cs_n}));
  // R2: read and write strobes exclusive, everything quiet in cycle 3
  p_oe_we_excl_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    !(!oe_n && !we_n));
  p_quiet_last_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase == 2'd3) |-> (sram_cs_n && eep_cs_n && ctl_cs_n && oe_n && we_n));
  p_strobe_inside_cs_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (!oe_n || !we_n) |-> !(sram_cs_n && eep_cs_n && ctl_cs_n));
  // R1: done strobes only at the end of the owner's slot
  p_host_done_slot_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    host_done |-> (phase == 2'd3 && host_slot));
  p_ch_done_slot_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    (|bdone_q) |-> (phase == 2'd3 && !host_slot));
  // R7: a channel slot only carries traffic if some channel was asking
  p_bm_req_held_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase == 2'd0 && !host_slot && act.valid) |-> $past(|(ch_wr_req | ch_rd_req)));
  // R11: nothing is selected before the first loaded slot
  p_reset_quiet_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (!act.valid) |-> (sram_cs_n && eep_cs_n && ctl_cs_n && oe_n && we_n));

endmodule

// File: tb/test_tdm_bus_arbiter.sv
module test_tdm_bus_arbiter;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_req, host_we;
  logic [1:0]  host_dev;
  logic [12:0] host_addr;
  logic [7:0]  host_wdata;
  logic        host_done;
  logic [7:0]  host_rdata;
  logic [2:0]  ch_wr_req, ch_rd_req, ch_wr_done, ch_rd_done;
  logic [23:0] ch_wdata;
  logic [7:0]  ch_rdata;
  logic [12:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        sram_cs_n, eep_cs_n, ctl_cs_n, oe_n, we_n;

  always #10 clk = ~clk;

  tdm_bus_arbiter i_tdm_bus_arbiter (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_we(host_we), .host_dev(host_dev),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_done(host_done), .host_rdata(host_rdata),
    .ch_wr_req(ch_wr_req), .ch_wdata(ch_wdata), .ch_wr_done(ch_wr_done),
    .ch_rd_req(ch_rd_req), .ch_rd_done(ch_rd_done), .ch_rdata(ch_rdata),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sram_cs_n(sram_cs_n), .eep_cs_n(eep_cs_n), .ctl_cs_n(ctl_cs_n),
    .oe_n(oe_n), .we_n(we_n)
  );

  // external device models
  logic [7:0] mem [int];
  always @(posedge clk) if (!sram_cs_n && !we_n) mem[int'(bus_addr)] = bus_wdata;
  always_comb begin
    bus_rdata = 8'hFF;
    if (!sram_cs_n)     bus_rdata = mem.exists(int'(bus_addr)) ? mem[int'(bus_addr)] : 8'h00;
    else if (!eep_cs_n) bus_rdata = bus_addr[7:0] ^ 8'hA5;
    else if (!ctl_cs_n) bus_rdata = bus_addr[7:0] ^ 8'h3C;
  end

  int n_checks = 0, n_err = 0, viol = 0, k, wd = 0;
  bit ended = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // cycle position relative to the design's schedule
  always @(posedge clk or negedge rst_n) if (!rst_n) k <= -2; else k <= k + 1;

  // R1 monitor: ownership of slots and position of done strobes
  always @(negedge clk) begin
    if (rst_n && k >= 0) begin
      if (((k / 4) % 2) == 0) begin
        if (!(sram_cs_n && eep_cs_n && ctl_cs_n) && !host_req) viol++;
        if (|{ch_wr_done, ch_rd_done}) viol++;
        if (host_done && (k % 4) != 3) viol++;
      end else begin
        if (host_done) viol++;
        if (|{ch_wr_done, ch_rd_done} && (k % 4) != 3) viol++;
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !ended) begin
      ended = 1;
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", wd, 150000);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  task automatic host_op(input logic [1:0] dev, input logic we, input logic [12:0] addr,
                         input logic [7:0] wd_in, input logic [1:0] ecs,
                         input logic [7:0] erd, input string tag);
    int cs_c = 0, oe_c = 0, we_c = 0;
    logic [1:0] seen = 2'd0;
    @(negedge clk);
    host_req = 1'b1; host_dev = dev; host_we = we; host_addr = addr; host_wdata = wd_in;
    do begin
      @(negedge clk);
      if (!sram_cs_n) begin cs_c++; seen = 2'd1; end
      if (!eep_cs_n)  begin cs_c++; seen = 2'd2; end
      if (!ctl_cs_n)  begin cs_c++; seen = 2'd3; end
      if (!oe_n) oe_c++;
      if (!we_n) we_c++;
    end while (!host_done);
    check(sram_cs_n && eep_cs_n && ctl_cs_n && oe_n && we_n, "R2", "strobes at done",
          {sram_cs_n, eep_cs_n, ctl_cs_n, oe_n, we_n}, 5'h1F);
    check(seen == ecs, tag, "device", seen, ecs);
    check(cs_c == ((ecs != 0) ? 3 : 0), "R2", "cs cycles", cs_c, (ecs != 0) ? 3 : 0);
    check(oe_c == ((ecs != 0 && !we) ? 2 : 0) && we_c == ((ecs != 0 && we) ? 2 : 0),
          "R2", "oe/we cycles", oe_c * 16 + we_c,
          ((ecs != 0 && !we) ? 32 : 0) + ((ecs != 0 && we) ? 2 : 0));
    if (!we) check(host_rdata == erd, tag, "read data", host_rdata, erd);
    host_req = 1'b0;
  endtask

  function automatic string rname(input int n);
    case (n)
      3: return "R3";  4: return "R4";  5: return "R5";
      8: return "R8";  9: return "R9";  10: return "R10";
      default: return "R?";
    endcase
  endfunction

  // {req, dev, we, addr, wdata, expected device, expected read data}
  localparam logic [37:0] VEC [13] = '{
    {4'd3,  2'd0, 1'b1, 13'h0123, 8'h5A, 2'd1, 8'h00},
    {4'd3,  2'd0, 1'b0, 13'h0123, 8'h00, 2'd1, 8'h5A},
    {4'd3,  2'd1, 1'b0, 13'h007F, 8'h00, 2'd2, 8'hDA},
    {4'd3,  2'd2, 1'b1, 13'h0003, 8'h11, 2'd3, 8'h00},
    {4'd3,  2'd2, 1'b0, 13'h0002, 8'h00, 2'd3, 8'h3E},
    {4'd9,  2'd3, 1'b0, 13'h000B, 8'h00, 2'd0, 8'h01},
    {4'd5,  2'd3, 1'b1, 13'h0003, 8'hC4, 2'd1, 8'h00},
    {4'd9,  2'd3, 1'b0, 13'h000B, 8'h00, 2'd0, 8'h00},
    {4'd4,  2'd0, 1'b0, 13'h0C00, 8'h00, 2'd1, 8'hC4},
    {4'd8,  2'd3, 1'b0, 13'h0000, 8'h00, 2'd0, 8'h00},
    {4'd10, 2'd3, 1'b1, 13'h0000, 8'h77, 2'd0, 8'h00},
    {4'd10, 2'd3, 1'b0, 13'h0006, 8'h00, 2'd0, 8'h00},
    {4'd5,  2'd3, 1'b1, 13'h0004, 8'h99, 2'd1, 8'h00}
  };

  initial begin
    int order [4];
    int nev;
    int cnt;
    rst_n = 1'b0; host_req = 0; host_we = 0; host_dev = 0; host_addr = 0; host_wdata = 0;
    ch_wr_req = 0; ch_rd_req = 0; ch_wdata = 0;
    repeat (4) @(negedge clk);
    // R11: quiet during reset
    check(sram_cs_n && eep_cs_n && ctl_cs_n && oe_n && we_n && !host_done &&
          ch_wr_done == 0 && ch_rd_done == 0, "R11", "reset outputs", 0, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(sram_cs_n && eep_cs_n && ctl_cs_n && oe_n && we_n && !host_done,
          "R11", "after reset", 0, 0);

    for (int i = 0; i < 13; i++) begin
      host_op(VEC[i][33:32], VEC[i][31], VEC[i][30:18], VEC[i][17:10],
              VEC[i][9:8], VEC[i][7:0], rname(int'(VEC[i][37:34])));
    end

    // R6: channel 0 pops transmit queue 3
    @(negedge clk); ch_rd_req = 3'b001;
    do @(negedge clk); while (!(|ch_rd_done));
    check(ch_rd_done == 3'b001 && ch_rdata == 8'hC4, "R6", "channel pop",
          {ch_rd_done, ch_rdata}, {3'b001, 8'hC4});
    ch_rd_req = 3'b000;
    host_op(2'd3, 1'b0, 13'h000B, 8'h00, 2'd0, 8'h01, "R9");

    // R7: rotation after queue 3 with queues 0,1,2,4 eligible -> 4,0,1,2
    ch_wdata = {8'h32, 8'h31, 8'h30};
    @(negedge clk); ch_wr_req = 3'b111; ch_rd_req = 3'b010;
    nev = 0;
    while (nev < 4) begin
      @(negedge clk);
      for (int c = 0; c < 3; c++) begin
        if (ch_wr_done[c] && nev < 4) begin order[nev] = c; nev++; ch_wr_req[c] = 1'b0; end
        if (ch_rd_done[c] && nev < 4) begin
          order[nev] = c + 3; nev++; ch_rd_req[c] = 1'b0;
          check(ch_rdata == 8'h99, "R6", "pop q4 data", ch_rdata, 8'h99);
        end
      end
    end
    check(order[0] == 4 && order[1] == 0 && order[2] == 1 && order[3] == 2, "R7",
          "service order", order[0]*4096 + order[1]*256 + order[2]*16 + order[3], 32'h4012);
    host_op(2'd0, 1'b0, 13'h0000, 8'h00, 2'd1, 8'h30, "R4");
    host_op(2'd0, 1'b0, 13'h0400, 8'h00, 2'd1, 8'h31, "R4");
    host_op(2'd0, 1'b0, 13'h0800, 8'h00, 2'd1, 8'h32, "R4");

    // R8: fill queue 0 (1 entry already) and confirm it stops at 1024
    ch_wdata = {8'h32, 8'h31, 8'h40};
    cnt = 0;
    @(negedge clk); ch_wr_req = 3'b001;
    for (int t = 0; t < 8600; t++) begin
      @(negedge clk);
      if (ch_wr_done[0]) cnt++;
    end
    ch_wr_req = 3'b000;
    check(cnt == 1023, "R8", "pushes until full", cnt, 1023);
    host_op(2'd3, 1'b0, 13'h0008, 8'h00, 2'd0, 8'h02, "R8");
    check(mem.exists(13'h03FF) && mem[13'h03FF] == 8'h40, "R4", "last slot of queue 0",
          mem.exists(13'h03FF) ? int'(mem[13'h03FF]) : -1, 8'h40);
    host_op(2'd3, 1'b0, 13'h0000, 8'h00, 2'd1, 8'h30, "R5");
    host_op(2'd3, 1'b0, 13'h0008, 8'h00, 2'd0, 8'h00, "R9");

    // R8: channel pop of empty queue 5 waits
    cnt = 0;
    @(negedge clk); ch_rd_req = 3'b100;
    for (int t = 0; t < 64; t++) begin
      @(negedge clk);
      if (|ch_rd_done) cnt++;
    end
    ch_rd_req = 3'b000;
    check(cnt == 0, "R8", "pop of empty queue", cnt, 0);

    check(viol == 0, "R1", "slot ownership violations", viol, 0);
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

endmodule